// File: doc/BRIEF.md
# Permissions Lookaside Buffer with Masked Tags

This block is a small, fully associative cache of protection-table results. It plays the same role for memory permissions that a TLB plays for address translation: a lookup that hits returns the cached permission in the same cycle, so no table access is needed. Table walking and checking the permission against the kind of access are left to neighbouring logic.

Each stored entry holds a tag, a don't-care mask over the low-order tag bits, and a permission code. A masked entry matches every address in an aligned power-of-two region, so one entry can cover a whole user segment. New results arrive through a fill port. After software changes permissions, stale entries are removed in one of two ways. A flush clears every entry. A masked invalidate clears every entry whose region overlaps the region named by the invalidate key and mask. Either operation completes in one cycle.

Fills go to a free slot when one exists. When every slot is valid, a round-robin pointer picks the victim. When an invalidate or a flush arrives in the same cycle as a fill, the invalidate or flush is performed and the fill is dropped.

Top module: `perm_lookaside`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup hits when some valid entry's tag equals the lookup address on every bit that the entry's mask does not mark don't-care (mask bit 1 = don't-care). `lk_hit` and `lk_perm` are combinational from `lk_addr`. A fill becomes visible from the cycle after it is presented.
- R3: A fill whose mask has its low k bits set creates an entry that matches exactly the aligned block of 2^k addresses containing the fill tag. Addresses one below or one above that block miss.
- R4: When several valid entries match a lookup, the permission comes from the matching entry with the lowest slot index.
- R5: An accepted fill is written into the lowest-indexed invalid slot whenever one exists, and in that case the round-robin pointer does not move.
- R6: When all slots are valid, an accepted fill overwrites the slot named by the round-robin pointer. The pointer starts at 0 after reset, advances by one on each such eviction, and wraps from ENTRIES-1 back to 0.
- R7: A masked invalidate clears, in one cycle, every valid entry whose tag equals the invalidate key on every bit that neither the entry mask nor the invalidate mask marks don't-care. All other entries are left unchanged.
- R8: A flush clears every entry in one cycle.
- R9: A fill presented in the same cycle as an invalidate or a flush is discarded. Flush takes precedence over invalidate.
- R10: On a miss, `lk_perm` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Lookup word address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_perm | output | PERM_W | Permission of the winning entry, zero on miss |
| fill_valid | input | 1 | Install an entry this cycle |
| fill_tag | input | ADDR_W | Address tag of the new entry |
| fill_mask | input | ADDR_W | Don't-care bits of the new entry (1 = ignore) |
| fill_perm | input | PERM_W | Permission of the new entry |
| inv_valid | input | 1 | Masked invalidate this cycle |
| inv_key | input | ADDR_W | Invalidate key address |
| inv_mask | input | ADDR_W | Don't-care bits of the invalidate key |
| flush | input | 1 | Clear all entries |

## Verification
The bench checks both edges of a masked region. A design that compared the mask against the wrong bits would hit one address outside the block or miss one inside it. It places a wide entry and an exact entry over the same address in both slot orders, which exposes any priority encoder that picks the highest match. The table is filled completely and then refilled through a full wrap of the pointer, with a hole punched in between, so a design that ignored free slots or advanced the pointer on a non-evicting fill would remove the wrong tag. Invalidates are issued in two forms: an inner key that lies inside a large entry, and a wide key that covers small entries. A design that applied only one side's mask would leave stale entries behind.

// File: rtl/perm_lb_pkg.sv
package perm_lb_pkg;

    localparam int unsigned DEF_ENTRIES = 60;
    localparam int unsigned DEF_ADDR_W  = 30;
    localparam int unsigned DEF_PERM_W  = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FILL  = 2'd1,
        OP_INV   = 2'd2,
        OP_FLUSH = 2'd3
    } plb_op_e;

    // Flush beats invalidate, both beat fill.
    function automatic plb_op_e decode_op(input logic fill_v, input logic inv_v, input logic flush_v);
        if (flush_v)     return OP_FLUSH;
        else if (inv_v)  return OP_INV;
        else if (fill_v) return OP_FILL;
        else             return OP_IDLE;
    endfunction

endpackage

// File: rtl/plb_prio_pick.sv
module plb_prio_pick #(
    parameter int unsigned N     = 60,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/plb_match_array.sv
module plb_match_array #(
    parameter int unsigned N      = 60,
    parameter int unsigned ADDR_W = 30
) (
    input  logic [ADDR_W-1:0]         lk_addr,
    input  logic [ADDR_W-1:0]         inv_key,
    input  logic [ADDR_W-1:0]         inv_mask,
    input  logic [N-1:0]              vld,
    input  logic [N-1:0][ADDR_W-1:0]  tag_v,
    input  logic [N-1:0][ADDR_W-1:0]  mask_v,
    output logic [N-1:0]              lk_match,
    output logic [N-1:0]              inv_hit
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [ADDR_W-1:0] lk_care;
        logic [ADDR_W-1:0] inv_care;
        assign lk_care     = ~mask_v[g];
        assign inv_care    = ~(mask_v[g] | inv_mask);
        assign lk_match[g] = vld[g] && (((tag_v[g] ^ lk_addr) & lk_care) == '0);
        assign inv_hit[g]  = vld[g] && (((tag_v[g] ^ inv_key) & inv_care) == '0);
    end

endmodule

// File: rtl/plb_victim.sv
module plb_victim #(
    parameter int unsigned N     = 60,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_d, rr_q;

    plb_prio_pick #(.N(N), .IDX_W(IDX_W)) u_free_pick (
        .req   (~vld),
        .found (free_found),
        .idx   (free_idx)
    );

    always_comb begin
        rr_d       = rr_q;
        victim_idx = free_found ? free_idx : rr_q;
        if (alloc && !free_found) begin
            rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    assert_rr_range_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= LAST);

    assert_rr_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (rr_q != $past(rr_q)) |->
            (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));

    assert_rr_hold_free_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && free_found) |=> $stable(rr_q));

endmodule

// File: rtl/perm_lookaside.sv
module perm_lookaside #(
    parameter int unsigned ENTRIES = perm_lb_pkg::DEF_ENTRIES,
    parameter int unsigned ADDR_W  = perm_lb_pkg::DEF_ADDR_W,
    parameter int unsigned PERM_W  = perm_lb_pkg::DEF_PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_tag,
    input  logic [ADDR_W-1:0] fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_key,
    input  logic [ADDR_W-1:0] inv_mask,
    input  logic              flush
);

    import perm_lb_pkg::*;

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] mask;
        logic [PERM_W-1:0] perm;
    } slot_t;

    slot_t ent_d [ENTRIES];
    slot_t ent_q [ENTRIES];

    logic [ENTRIES-1:0]             vld_vec;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_vec;
    logic [ENTRIES-1:0][ADDR_W-1:0] mask_vec;
    logic [ENTRIES-1:0]             lk_match;
    logic [ENTRIES-1:0]             inv_hit;
    logic                           hit_found;
    logic [IDX_W-1:0]               hit_idx;
    logic [IDX_W-1:0]               victim_idx;
    plb_op_e                        op;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign vld_vec[g]  = ent_q[g].valid;
        assign tag_vec[g]  = ent_q[g].tag;
        assign mask_vec[g] = ent_q[g].mask;
    end

    assign op = decode_op(fill_valid, inv_valid, flush);

    plb_match_array #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .lk_addr  (lk_addr),
        .inv_key  (inv_key),
        .inv_mask (inv_mask),
        .vld      (vld_vec),
        .tag_v    (tag_vec),
        .mask_v   (mask_vec),
        .lk_match (lk_match),
        .inv_hit  (inv_hit)
    );

    plb_prio_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_pick (
        .req   (lk_match),
        .found (hit_found),
        .idx   (hit_idx)
    );

    plb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (vld_vec),
        .alloc      (op == OP_FILL),
        .victim_idx (victim_idx)
    );

    assign lk_hit  = hit_found;
    assign lk_perm = hit_found ? ent_q[hit_idx].perm : '0;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) ent_d[i] = ent_q[i];
        unique case (op)
            OP_FLUSH: begin
                for (int i = 0; i < ENTRIES; i++) ent_d[i].valid = 1'b0;
            end
            OP_INV: begin
                for (int i = 0; i < ENTRIES; i++)
                    if (inv_hit[i]) ent_d[i].valid = 1'b0;
            end
            OP_FILL: begin
                ent_d[victim_idx].valid = 1'b1;
                ent_d[victim_idx].tag   = fill_tag & ~fill_mask;
                ent_d[victim_idx].mask  = fill_mask;
                ent_d[victim_idx].perm  = fill_perm;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    assert_reset_empty_R1 : assert property (@(posedge clk)
        !rst_n |=> (vld_vec == '0));

    assert_flush_clears_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    assert_inv_clears_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !flush) |=> ((vld_vec & $past(inv_hit)) == '0));

    assert_fill_dropped_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && (inv_valid || flush)) |=>
            ($countones(vld_vec) <= $past($countones(vld_vec))));

    assert_miss_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_perm == '0));

    assert_hit_lowest_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_match & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

endmodule

// File: tb/perm_lookaside_tb.sv
module perm_lookaside_tb;

    localparam int unsigned ENTRIES = 60;
    localparam int unsigned ADDR_W  = 30;
    localparam int unsigned PERM_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [PERM_W-1:0] lk_perm;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_tag = '0;
    logic [ADDR_W-1:0] fill_mask = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic              inv_valid = 1'b0;
    logic [ADDR_W-1:0] inv_key = '0;
    logic [ADDR_W-1:0] inv_mask = '0;
    logic              flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    perm_lookaside #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PERM_W(PERM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_perm(lk_perm),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_mask(fill_mask),
        .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_key(inv_key),
        .inv_mask(inv_mask), .flush(flush)
    );

    // Look up an address and compare hit and permission (miss implies zero permission).
    task automatic look(input logic [ADDR_W-1:0] a, input bit exp_hit,
                        input logic [PERM_W-1:0] exp_perm, input string req);
        logic [PERM_W-1:0] ep;
        ep = exp_hit ? exp_perm : '0;
        lk_addr = a;
        #1;
        checks++;
        if (lk_hit !== exp_hit || lk_perm !== ep) begin
            errors++;
            $display("FAIL %s addr=%h hit=%0b perm=%0d expected hit=%0b perm=%0d",
                     req, a, lk_hit, lk_perm, exp_hit, ep);
        end
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] t, input logic [ADDR_W-1:0] m,
                           input logic [PERM_W-1:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = t; fill_mask = m; fill_perm = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [ADDR_W-1:0] k, input logic [ADDR_W-1:0] m);
        @(negedge clk);
        inv_valid = 1'b1; inv_key = k; inv_mask = m;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look(30'h0, 0, 0, "R1");
        look(30'h123, 0, 0, "R1");
    endtask

    task automatic t_basic();
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = 30'h100; fill_mask = '0; fill_perm = 2'd2;
        look(30'h100, 0, 0, "R2 before edge");
        @(negedge clk);
        fill_valid = 1'b0;
        look(30'h100, 1, 2'd2, "R2");
        look(30'h101, 0, 0, "R10");
    endtask

    task automatic t_region();
        do_fill(30'h2005, 30'hF, 2'd3);
        look(30'h2000, 1, 2'd3, "R3 low end");
        look(30'h200F, 1, 2'd3, "R3 high end");
        look(30'h2010, 0, 0, "R3 above");
        look(30'h1FFF, 0, 0, "R3 below");
    endtask

    task automatic t_priority();
        do_flush();
        do_fill(30'h3004, 30'h0, 2'd1);
        do_fill(30'h3000, 30'h7, 2'd2);
        look(30'h3004, 1, 2'd1, "R4 exact first");
        look(30'h3005, 1, 2'd2, "R4");
        do_flush();
        do_fill(30'h3000, 30'h7, 2'd2);
        do_fill(30'h3004, 30'h0, 2'd1);
        look(30'h3004, 1, 2'd2, "R4 wide first");
    endtask

    task automatic t_invalidate();
        do_flush();
        do_fill(30'h4000, 30'h0, 2'd1);
        do_fill(30'h4010, 30'hF, 2'd2);
        do_fill(30'h5000, 30'h0, 2'd3);
        do_fill(30'h4100, 30'h0, 2'd1);
        do_fill(30'h6000, 30'hFFF, 2'd1);
        do_inv(30'h4000, 30'hFF);
        look(30'h4000, 0, 0, "R7 inside key");
        look(30'h4013, 0, 0, "R7 masked entry inside key");
        look(30'h5000, 1, 2'd3, "R7 untouched");
        look(30'h4100, 1, 2'd1, "R7 just outside key");
        look(30'h6123, 1, 2'd1, "R7 large entry before");
        do_inv(30'h6123, 30'h0);
        look(30'h6FFF, 0, 0, "R7 key inside entry");
        look(30'h5000, 1, 2'd3, "R7 untouched after second");
    endtask

    task automatic t_flush();
        do_fill(30'h7777, 30'h0, 2'd1);
        do_flush();
        look(30'h7777, 0, 0, "R8");
        look(30'h5000, 0, 0, "R8");
    endtask

    task automatic t_conflict();
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = 30'h7000; fill_mask = '0; fill_perm = 2'd1;
        inv_valid = 1'b1; inv_key = 30'h9999; inv_mask = '0;
        @(negedge clk);
        fill_valid = 1'b0; inv_valid = 1'b0;
        look(30'h7000, 0, 0, "R9 with invalidate");
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = 30'h7100; flush = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; flush = 1'b0;
        look(30'h7100, 0, 0, "R9 with flush");
    endtask

    task automatic t_replace();
        do_flush();
        for (int i = 0; i < ENTRIES; i++) do_fill(30'h8000 + 30'(i), '0, 2'((i % 3) + 1));
        look(30'h8000, 1, 2'd1, "R5 slot 0");
        look(30'h8000 + 30'(ENTRIES - 1), 1, 2'(((ENTRIES - 1) % 3) + 1), "R5 last slot");
        do_fill(30'h9000, '0, 2'd3);
        look(30'h8000, 0, 0, "R6 first victim");
        look(30'h8001, 1, 2'd2, "R6");
        look(30'h9000, 1, 2'd3, "R6");
        do_fill(30'h9001, '0, 2'd3);
        look(30'h8001, 0, 0, "R6 second victim");
        do_inv(30'h8005, '0);
        do_fill(30'h9002, '0, 2'd1);
        look(30'h8002, 1, 2'd3, "R5 free slot used");
        look(30'h9002, 1, 2'd1, "R5");
        do_fill(30'h9003, '0, 2'd2);
        look(30'h8002, 0, 0, "R6 pointer held");
        for (int j = 0; j < ENTRIES - 3; j++) do_fill(30'hA000 + 30'(j), '0, 2'd1);
        look(30'h9000, 1, 2'd3, "R6 before wrap");
        do_fill(30'hB000, '0, 2'd2);
        look(30'h9000, 0, 0, "R6 wrap");
        look(30'h9001, 1, 2'd3, "R6 wrap");
        look(30'hB000, 1, 2'd2, "R6 wrap");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_region();
        t_priority();
        t_invalidate();
        t_flush();
        t_conflict();
        t_replace();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule